// File: doc/BRIEF.md
# USB Controller Interrupt Wrapper

This block sits beside a USB dual-role controller core and gathers its event pulses into one level interrupt for the host processor. Per-endpoint transmit and receive completions and nine core events each latch into a raw source word. Each raw word has an enable mask next to it and a read-only masked view. Software reaches every source and mask word three ways: a direct load, a write-one-to-set alias and a write-one-to-clear alias. This lets a driver raise a core event by itself, for example a forced VBUS-drive change, without a read-modify-write.

The interrupt line is gated by an arm flag. Once the line has asserted, it cannot assert again until software writes the end-of-interrupt register. A service routine therefore reads the masked views, acknowledges the bits through the clear aliases, and finishes with the end-of-interrupt write. The wrapper also holds a soft-reset request bit for the core, shows the live VBUS-drive level, and returns a fixed nonzero revision code so that software can detect that the block is present.

Top module: `usbirq_wrap`

## Requirements
- R1: After reset, every source and mask word reads 0, irq and soft_rst_req are low, and the revision word at 0x00 reads the nonzero parameter REV_ID.
- R2: Endpoint words (source 0x20, set 0x24, clear 0x28, mask 0x2C, mask-set 0x30, mask-clear 0x34, masked 0x38) carry transmit endpoint k in bit k (k = 0..15) and receive endpoint k in bit 16+k (k = 1..15); bit 16 always reads 0. Core words (source 0x40, set 0x44, clear 0x48, mask 0x4C, mask-set 0x50, mask-clear 0x54, masked 0x58) carry core event j in bit 16+j (j = 0..8, VBUS-drive change is j = 8, bit 24); all other core bits always read 0.
- R3: A high hardware event input sets its raw source bit at the next clock edge, and wins over a software clear of the same bit in the same cycle.
- R4: A write to a set alias sets the source bits written as 1, a write to a clear alias clears them, and all other bits keep their values. A write to the base source address loads the word.
- R5: Masks follow the same load, set and clear rules at their own addresses, and each masked view reads source AND mask.
- R6: irq rises one clock edge after a masked bit becomes set while the wrapper is armed. It stays high while any masked bit is set, and falls one edge after no masked bit is set.
- R7: Once irq has asserted, it does not assert again until a write to 0x60. That write drives irq low at the next edge and re-arms the line, so irq rises one edge later if a masked bit is still set.
- R8: Writes to the revision word, the status word (0x08), the masked views and the reserved offsets 0x10 and 0x5C change nothing.
- R9: Status bit 0 (0x08) reads the present level of the vbus_drv input; its other bits read 0.
- R10: Control bit 0 (0x04) is a writable, readable soft-reset request that drives the soft_rst_req output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (8) | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tx_evt | input | NTX (16) | Transmit endpoint event pulses |
| rx_evt | input | NRX (15) | Receive endpoint 1..15 event pulses |
| core_evt | input | NCORE (9) | Core event pulses |
| vbus_drv | input | 1 | VBUS-drive level from the core |
| soft_rst_req | output | 1 | Soft-reset request to the core |
| irq | output | 1 | Level interrupt to the host |

## Verification
Register effects of a write or an event pulse appear one edge later, and the masked views and status read back combinationally. irq follows the raw source by one further edge, so it lags a stimulus by two edges. The bench drives every stimulus at a falling edge. After a write or pulse returns, source and mask words are compared at once. The irq level is compared only after one more rising edge has passed. The end-of-interrupt drop is compared immediately after the write, before the re-armed rise that follows one edge later.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;
   localparam int unsigned OFF_REV      = 'h00;
   localparam int unsigned OFF_CTRL     = 'h04;
   localparam int unsigned OFF_STAT     = 'h08;
   localparam int unsigned OFF_EP_SRC   = 'h20;
   localparam int unsigned OFF_EP_SET   = 'h24;
   localparam int unsigned OFF_EP_CLR   = 'h28;
   localparam int unsigned OFF_EP_MSK   = 'h2C;
   localparam int unsigned OFF_EP_MSET  = 'h30;
   localparam int unsigned OFF_EP_MCLR  = 'h34;
   localparam int unsigned OFF_EP_MSKD  = 'h38;
   localparam int unsigned OFF_CO_SRC   = 'h40;
   localparam int unsigned OFF_CO_SET   = 'h44;
   localparam int unsigned OFF_CO_CLR   = 'h48;
   localparam int unsigned OFF_CO_MSK   = 'h4C;
   localparam int unsigned OFF_CO_MSET  = 'h50;
   localparam int unsigned OFF_CO_MCLR  = 'h54;
   localparam int unsigned OFF_CO_MSKD  = 'h58;
   localparam int unsigned OFF_EOI      = 'h60;

   localparam int unsigned WORD_W = 32;

   typedef struct packed {
      logic ld;
      logic set;
      logic clr;
      logic mld;
      logic mset;
      logic mclr;
   } bank_wr_t;
endpackage

// File: rtl/usbirq_bank.sv
module usbirq_bank #(
   parameter int unsigned          W     = 32,
   parameter logic [W-1:0]         VALID = '1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  usbirq_pkg::bank_wr_t         wr,
   input  logic [W-1:0]                 wdata,
   input  logic [W-1:0]                 hw_set,
   output logic [W-1:0]                 src_q,
   output logic [W-1:0]                 msk_q,
   output logic [W-1:0]                 masked
);
   logic unused_bits;
   assign unused_bits = ^((wdata | hw_set) & ~VALID);

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (VALID[i]) begin : g_live
         logic src_d, msk_d;
         always_comb begin
            src_d = src_q[i];
            if (wr.ld)                  src_d = wdata[i];
            else if (wr.set && wdata[i]) src_d = 1'b1;
            else if (wr.clr && wdata[i]) src_d = 1'b0;
            src_d = src_d | hw_set[i];
            msk_d = msk_q[i];
            if (wr.mld)                  msk_d = wdata[i];
            else if (wr.mset && wdata[i]) msk_d = 1'b1;
            else if (wr.mclr && wdata[i]) msk_d = 1'b0;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               src_q[i] <= 1'b0;
               msk_q[i] <= 1'b0;
            end else begin
               src_q[i] <= src_d;
               msk_q[i] <= msk_d;
            end
         end
      end else begin : g_hole
         assign src_q[i] = 1'b0;
         assign msk_q[i] = 1'b0;
      end
   end

   assign masked = src_q & msk_q;
endmodule

// File: rtl/usbirq_arm.sv
module usbirq_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic pending,
   input  logic eoi,
   output logic irq,
   output logic armed
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b1;
         irq   <= 1'b0;
      end else if (eoi) begin
         armed <= 1'b1;
         irq   <= 1'b0;
      end else begin
         irq <= pending & (armed | irq);
         if (pending) armed <= 1'b0;
      end
   end
endmodule

// File: rtl/usbirq_wrap.sv
module usbirq_wrap #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned NTX      = 16,
   parameter int unsigned NRX      = 15,
   parameter int unsigned NCORE    = 9,
   parameter int unsigned CORE_LSB = 16,
   parameter logic [31:0] REV_ID   = 32'h0001_0A05
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NTX-1:0]    tx_evt,
   input  logic [NRX-1:0]    rx_evt,
   input  logic [NCORE-1:0]  core_evt,
   input  logic              vbus_drv,
   output logic              soft_rst_req,
   output logic              irq
);
   import usbirq_pkg::*;

   localparam int unsigned RX_LSB = NTX + 1;
   localparam logic [31:0] EP_VALID =
      32'((64'(1) << NTX) - 64'(1)) | 32'(((64'(1) << NRX) - 64'(1)) << RX_LSB);
   localparam logic [31:0] CORE_VALID =
      32'(((64'(1) << NCORE) - 64'(1)) << CORE_LSB);

   if (ADDR_W < 7) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end
   if (RX_LSB + NRX > WORD_W) begin : g_bad_ep
      $error("endpoint fields exceed one word");
   end
   if (CORE_LSB + NCORE > WORD_W) begin : g_bad_core
      $error("core field exceeds one word");
   end
   if (REV_ID == 32'h0) begin : g_bad_rev
      $error("REV_ID must be nonzero");
   end

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned off);
      return a == ADDR_W'(off);
   endfunction

   bank_wr_t ep_wr, core_wr;
   logic     eoi_wr, ctrl_wr;
   always_comb begin
      ep_wr.ld     = bus_we && hit(bus_addr, OFF_EP_SRC);
      ep_wr.set    = bus_we && hit(bus_addr, OFF_EP_SET);
      ep_wr.clr    = bus_we && hit(bus_addr, OFF_EP_CLR);
      ep_wr.mld    = bus_we && hit(bus_addr, OFF_EP_MSK);
      ep_wr.mset   = bus_we && hit(bus_addr, OFF_EP_MSET);
      ep_wr.mclr   = bus_we && hit(bus_addr, OFF_EP_MCLR);
      core_wr.ld   = bus_we && hit(bus_addr, OFF_CO_SRC);
      core_wr.set  = bus_we && hit(bus_addr, OFF_CO_SET);
      core_wr.clr  = bus_we && hit(bus_addr, OFF_CO_CLR);
      core_wr.mld  = bus_we && hit(bus_addr, OFF_CO_MSK);
      core_wr.mset = bus_we && hit(bus_addr, OFF_CO_MSET);
      core_wr.mclr = bus_we && hit(bus_addr, OFF_CO_MCLR);
      eoi_wr       = bus_we && hit(bus_addr, OFF_EOI);
      ctrl_wr      = bus_we && hit(bus_addr, OFF_CTRL);
   end

   logic [31:0] ep_hw, core_hw;
   always_comb begin
      ep_hw                   = '0;
      ep_hw[NTX-1:0]          = tx_evt;
      ep_hw[RX_LSB +: NRX]    = rx_evt;
      core_hw                 = '0;
      core_hw[CORE_LSB +: NCORE] = core_evt;
   end

   logic [31:0] ep_src, ep_msk, ep_mskd;
   logic [31:0] core_src, core_msk, core_mskd;

   usbirq_bank #(.W(WORD_W), .VALID(EP_VALID)) i_ep_bank (
      .clk(clk), .rst_n(rst_n), .wr(ep_wr), .wdata(bus_wdata),
      .hw_set(ep_hw), .src_q(ep_src), .msk_q(ep_msk), .masked(ep_mskd)
   );

   usbirq_bank #(.W(WORD_W), .VALID(CORE_VALID)) i_core_bank (
      .clk(clk), .rst_n(rst_n), .wr(core_wr), .wdata(bus_wdata),
      .hw_set(core_hw), .src_q(core_src), .msk_q(core_msk), .masked(core_mskd)
   );

   logic pending, armed;
   assign pending = (|ep_mskd) | (|core_mskd);

   usbirq_arm i_arm (
      .clk(clk), .rst_n(rst_n), .pending(pending), .eoi(eoi_wr),
      .irq(irq), .armed(armed)
   );

   logic ctrl_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= 1'b0;
      else if (ctrl_wr) ctrl_q <= bus_wdata[0];
   end
   assign soft_rst_req = ctrl_q;

   always_comb begin
      bus_rdata = '0;
      if      (hit(bus_addr, OFF_REV))     bus_rdata = REV_ID;
      else if (hit(bus_addr, OFF_CTRL))    bus_rdata = {31'b0, ctrl_q};
      else if (hit(bus_addr, OFF_STAT))    bus_rdata = {31'b0, vbus_drv};
      else if (hit(bus_addr, OFF_EP_SRC))  bus_rdata = ep_src;
      else if (hit(bus_addr, OFF_EP_MSK))  bus_rdata = ep_msk;
      else if (hit(bus_addr, OFF_EP_MSKD)) bus_rdata = ep_mskd;
      else if (hit(bus_addr, OFF_CO_SRC))  bus_rdata = core_src;
      else if (hit(bus_addr, OFF_CO_MSK))  bus_rdata = core_msk;
      else if (hit(bus_addr, OFF_CO_MSKD)) bus_rdata = core_mskd;
   end
endmodule

// File: rtl/usbirq_chk.sv
module usbirq_chk #(
   parameter int unsigned NTX      = 16,
   parameter int unsigned NCORE    = 9,
   parameter int unsigned CORE_LSB = 16
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NTX-1:0] tx_evt,
   input logic           irq,
   input logic           eoi_wr,
   input logic           armed,
   input logic           pending,
   input logic [31:0]    ep_src,
   input logic [31:0]    core_src
);
   localparam logic [31:0] CORE_VALID =
      32'(((64'(1) << NCORE) - 64'(1)) << CORE_LSB);

   // R3: every transmit pulse leaves its raw bit set one edge later
   a_r3_hw_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_evt != '0) |=> ((ep_src[NTX-1:0] & $past(tx_evt)) == $past(tx_evt)));

   // R7: a rising edge of irq needs the arm flag of the cycle before
   a_r7_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(armed));

   // R7: an end-of-interrupt write drops the line
   a_r7_eoi_drops: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_wr |=> !irq);

   // R6: nothing masked means no line one edge later
   a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !pending |=> !irq);

   // R6: armed and pending raises the line
   a_r6_fires: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && armed && !eoi_wr) |=> irq);

   // R2: unused bit positions never hold a value
   a_r2_holes: assert property (@(posedge clk) disable iff (!rst_n)
      !ep_src[NTX] && ((core_src & ~CORE_VALID) == 32'h0));
endmodule

bind usbirq_wrap usbirq_chk #(.NTX(NTX), .NCORE(NCORE), .CORE_LSB(CORE_LSB)) i_chk (
   .clk(clk), .rst_n(rst_n), .tx_evt(tx_evt), .irq(irq), .eoi_wr(eoi_wr),
   .armed(armed), .pending(pending), .ep_src(ep_src), .core_src(core_src)
);

// File: tb/test_usbirq_wrap.sv
module test_usbirq_wrap;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] REV = 32'h0001_0A05;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] tx_evt = '0;
   logic [14:0] rx_evt = '0;
   logic [8:0]  core_evt = '0;
   logic        vbus_drv = 1'b0;
   logic        soft_rst_req, irq;

   usbirq_wrap #(.REV_ID(REV)) i_usbirq_wrap (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_evt(tx_evt),
      .rx_evt(rx_evt), .core_evt(core_evt), .vbus_drv(vbus_drv),
      .soft_rst_req(soft_rst_req), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      int          kind;   // 0 read word, 1 irq, 2 soft_rst_req
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // monitor: pops each expected item and compares one time unit later
   initial begin
      forever begin
         wait (q.size() > 0);
         #1;
         begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
               0:       act = bus_rdata;
               1:       act = {31'b0, irq};
               default: act = {31'b0, soft_rst_req};
            endcase
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic push(input int kind, input logic [31:0] exp, input string tag);
      item_t it;
      it.kind = kind; it.exp = exp; it.tag = tag;
      q.push_back(it);
      wait (q.size() == 0);
      #1;
   endtask

   task automatic expect_reg(input logic [7:0] a, input logic [31:0] exp, input string tag);
      bus_addr = a;
      push(0, exp, tag);
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic pulse(input logic [15:0] t, input logic [14:0] r, input logic [8:0] c);
      @(negedge clk);
      tx_evt = t; rx_evt = r; core_evt = c;
      @(negedge clk);
      tx_evt = '0; rx_evt = '0; core_evt = '0;
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      // R1 reset state
      expect_reg(8'h00, REV, "R1 revision");
      expect_reg(8'h20, 32'h0, "R1 ep source");
      expect_reg(8'h4C, 32'h0, "R1 core mask");
      expect_reg(8'h04, 32'h0, "R1 control");
      push(1, 32'h0, "R1 irq low");

      // R3 / R2 hardware pulses and field layout
      pulse(16'h0005, 15'h0, 9'h0);
      expect_reg(8'h20, 32'h0000_0005, "R3 tx pulse sets raw bits");
      pulse(16'h0, 15'h4001, 9'h0);
      expect_reg(8'h20, 32'h8002_0005, "R2 rx ep1 and ep15 at bits 17 and 31");

      // R4 set and clear aliases, R2 bit 16 hole
      wr(8'h24, 32'h0001_0100);
      expect_reg(8'h20, 32'h8002_0105, "R2 R4 set alias, bit 16 stays 0");
      wr(8'h28, 32'h8000_0001);
      expect_reg(8'h20, 32'h0002_0104, "R4 clear alias");

      // R5 mask and masked view, R6 irq
      wr(8'h30, 32'h0000_0104);
      expect_reg(8'h2C, 32'h0000_0104, "R5 mask set alias");
      expect_reg(8'h38, 32'h0000_0104, "R5 masked view");
      push(1, 32'h0, "R6 irq not before its edge");
      tick();
      push(1, 32'h1, "R6 irq rises");

      // R6 fall when cleared, R7 no re-assert without EOI
      wr(8'h28, 32'h0000_0104);
      tick();
      push(1, 32'h0, "R6 irq falls when nothing masked");
      pulse(16'h0004, 15'h0, 9'h0);
      tick(); tick();
      expect_reg(8'h38, 32'h0000_0004, "R5 masked view after new event");
      push(1, 32'h0, "R7 no re-assert before EOI");
      wr(8'h60, 32'h0);
      push(1, 32'h0, "R7 irq still low right after EOI");
      tick();
      push(1, 32'h1, "R7 irq rises after EOI re-arm");
      wr(8'h60, 32'h0);
      push(1, 32'h0, "R7 EOI drops asserted irq");
      tick();
      push(1, 32'h1, "R7 irq back one edge after EOI");

      // R5 mask clear alias
      wr(8'h34, 32'h0000_0100);
      expect_reg(8'h2C, 32'h0000_0004, "R5 mask clear alias");
      wr(8'h28, 32'h0000_0004);
      tick();
      push(1, 32'h0, "R6 irq low after acknowledge");
      wr(8'h60, 32'h0);

      // core word
      pulse(16'h0, 15'h0, 9'h100);
      expect_reg(8'h40, 32'h0100_0000, "R2 VBUS-drive event at bit 24");
      wr(8'h4C, 32'hFFFF_FFFF);
      expect_reg(8'h4C, 32'h01FF_0000, "R2 R5 core mask load keeps holes 0");
      expect_reg(8'h58, 32'h0100_0000, "R5 core masked view");
      tick();
      push(1, 32'h1, "R6 irq from core event");
      wr(8'h44, 32'hFFFF_FFFF);
      expect_reg(8'h40, 32'h01FF_0000, "R4 core set alias");

      // R8 ignored writes
      wr(8'h00, 32'h0);
      wr(8'h58, 32'h0);
      wr(8'h38, 32'hFFFF_FFFF);
      wr(8'h08, 32'hFFFF_FFFF);
      wr(8'h10, 32'hFFFF_FFFF);
      wr(8'h5C, 32'hFFFF_FFFF);
      expect_reg(8'h00, REV, "R8 revision unchanged");
      expect_reg(8'h58, 32'h01FF_0000, "R8 core masked unchanged");
      expect_reg(8'h20, 32'h0002_0000, "R8 ep source unchanged");
      expect_reg(8'h2C, 32'h0000_0004, "R8 ep mask unchanged");
      expect_reg(8'h04, 32'h0, "R8 control unchanged");

      // R3 hardware wins over same-cycle clear
      @(negedge clk);
      bus_addr = 8'h48; bus_wdata = 32'h0100_0000; bus_we = 1'b1; core_evt = 9'h100;
      @(negedge clk);
      bus_we = 1'b0; core_evt = '0;
      expect_reg(8'h40, 32'h01FF_0000, "R3 event wins over clear");
      wr(8'h48, 32'hFFFF_FFFF);
      expect_reg(8'h40, 32'h0, "R4 core clear all");
      tick();
      push(1, 32'h0, "R6 irq low after core clear");

      // R4 direct load of ep source
      wr(8'h20, 32'h0001_0003);
      expect_reg(8'h20, 32'h0000_0003, "R4 direct load, hole dropped");

      // R9 status
      vbus_drv = 1'b1;
      expect_reg(8'h08, 32'h1, "R9 status high");
      vbus_drv = 1'b0;
      expect_reg(8'h08, 32'h0, "R9 status low");

      // R10 control
      wr(8'h04, 32'hFFFF_FFFF);
      expect_reg(8'h04, 32'h1, "R10 control reads 1");
      push(2, 32'h1, "R10 soft reset request high");
      wr(8'h04, 32'h0);
      push(2, 32'h0, "R10 soft reset request low");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule